// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits behind the control pins of a synchronous DRAM interface and turns each clock's chip select, row strobe, column strobe, write enable, clock enable, bank and address inputs into one decoded command. It keeps, for each bank, whether a row is open and which row that is. It judges every command against that state and against minimum clock spacings held in per-bank and global down-counters. A command judged illegal is flagged and changes no state.

It also produces the two data-mask timings: a write-mask output that follows the mask input in the same clock, and a read high-impedance output that follows it two clocks later. A mode input selects between two input paths. In one, every control input passes through a capture register and is acted on one clock later. In the other, inputs are acted on in the clock they arrive.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: With `cs_n` high the command is inhibit (code 0) whatever the other inputs. With `cs_n` low, `{ras_n,cas_n,we_n}` gives: 111 no-op (1), 011 activate (2), 101 read (3), 100 write (4), 110 burst stop (5), 010 precharge (6), 001 refresh, 000 mode-register load (9). Inhibit, no-op and burst stop are always legal.
- R2: Code 001 decodes as auto refresh (7) when `cke` is high and as self-refresh entry (8) when `cke` is low. Both are legal only when all banks are idle and the mode-load spacing has elapsed.
- R3: A legal activate sets the open bit of the bank given by `ba` in the following clock. It also stores `addr` as that bank's row, which is shown on `bank_row[ba*ROW_W +: ROW_W]`.
- R4: A read or write to an idle bank, or an activate to an open bank, drives `cmd_ok` low and leaves every bank's open bit and row unchanged.
- R5: A read or write to an open bank is legal only from the T_RCD-th clock after that bank's activate (default 3).
- R6: A precharge of an open bank is legal only from the T_RAS-th clock after its activate (default 6). Precharging an idle bank is legal.
- R7: A precharge with `addr[10]` high closes every bank and ignores `ba`. With `addr[10]` low it closes only the bank given by `ba`.
- R8: A legal read or write with `addr[10]` high closes its bank in the following clock. With `addr[10]` low the bank stays open. The choice applies to that command only.
- R9: After a legal mode-register load, activate and refresh are illegal until T_MRD clocks have passed (default 2). Mode-register load and refresh are illegal while any bank is open.
- R10: `wr_mask` equals the accepted `dqm` in the same clock. `rd_hiz` equals the accepted `dqm` of two clocks earlier.
- R11: With `reg_en` high, every input is acted on one clock after it is presented. With `reg_en` low, it is acted on in the same clock.
- R12: After reset all banks are idle and `rd_hiz` is low. In registered mode the decoded command is inhibit until the first input capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_en | input | 1 | 1: one-clock registered input path, 0: same-clock path |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable, selects refresh type |
| ba | input | BA_W | Bank address |
| addr | input | ROW_W | Row / column address; bit 10 qualifies precharge |
| dqm | input | 1 | Data mask |
| cmd | output | 4 | Decoded command code |
| cmd_ok | output | 1 | Command is legal in the present state |
| bank_open | output | NUM_BANKS | Open bit per bank |
| bank_row | output | NUM_BANKS*ROW_W | Open row per bank, bank 0 in the low bits |
| wr_mask | output | 1 | Write data mask, zero latency |
| rd_hiz | output | 1 | Read output high-Z, two-clock latency |

## Verification
The bench probes the clock exactly before and after each spacing counter expires. A design off by one cycle there would accept a column command or a precharge one clock early, or reject a legal one. It issues illegal activates and column commands with a different row on `addr`. A design that updated state before judging legality would overwrite the stored row or open bit. Precharge is tested with `addr[10]` high and an idle bank on `ba`, which catches designs that close only the addressed bank. The refresh code is tested with both `cke` levels, and the mask timing is tested in both input modes. Getting either wrong shows up as a one-clock shift or a swapped command code.

// File: rtl/sdr_cmd_pkg.sv
package sdr_cmd_pkg;
    typedef enum logic [3:0] {
        CMD_INH  = 4'd0,
        CMD_NOP  = 4'd1,
        CMD_ACT  = 4'd2,
        CMD_RD   = 4'd3,
        CMD_WR   = 4'd4,
        CMD_BST  = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_AREF = 4'd7,
        CMD_SREF = 4'd8,
        CMD_LMR  = 4'd9
    } cmd_e;
endpackage

// File: rtl/sdr_in_stage.sv
// Input path: optional one-clock capture register (R11).
module sdr_in_stage #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_en,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = d_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= RST_VAL;
        else        cap_q <= cap_d;
    end

    assign d_out = reg_en ? cap_q : d_in;
endmodule

// File: rtl/sdr_cmd_decode.sv
// Pin pattern to command code (R1, R2).
module sdr_cmd_decode
    import sdr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output cmd_e cmd
);
    always_comb begin
        if (cs_n) begin
            cmd = CMD_INH;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                default: cmd = CMD_LMR;
            endcase
        end
    end
endmodule

// File: rtl/sdr_bank_slot.sv
// One bank: open bit, row, activate-to-column and activate-to-precharge counters.
module sdr_bank_slot #(
    parameter int ROW_W = 12,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_go,
    input  logic             close_go,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row,
    output logic             col_ready,
    output logic             pre_ready
);
    localparam int TMAX = (T_RCD > T_RAS) ? T_RCD : T_RAS;
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CW-1:0]    rcd;
        logic [CW-1:0]    ras;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.rcd != '0) st_d.rcd = st_q.rcd - CW'(1);
        if (st_q.ras != '0) st_d.ras = st_q.ras - CW'(1);
        if (open_go) begin
            st_d.open = 1'b1;
            st_d.row  = row_in;
            st_d.rcd  = CW'(T_RCD - 1);
            st_d.ras  = CW'(T_RAS - 1);
        end else if (close_go) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_open   = st_q.open;
    assign row       = st_q.row;
    assign col_ready = st_q.open && (st_q.rcd == '0);
    assign pre_ready = !st_q.open || (st_q.ras == '0);
endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
    import sdr_cmd_pkg::*;
#(
    parameter int  ROW_W     = 12,
    parameter int  NUM_BANKS = 4,
    parameter int  AP_BIT    = 10,
    parameter int  T_RCD     = 3,
    parameter int  T_RAS     = 6,
    parameter int  T_MRD     = 2,
    localparam int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_en,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic                       cke,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    input  logic                       dqm,
    output logic [3:0]                 cmd,
    output logic                       cmd_ok,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row,
    output logic                       wr_mask,
    output logic                       rd_hiz
);
    localparam int IW = ROW_W + BA_W + 6;
    localparam int MW = $clog2(T_MRD + 1);
    localparam logic [IW-1:0] IDLE_VEC = {1'b1, 1'b0, 4'b1111, {(BA_W + ROW_W){1'b0}}};

    logic [IW-1:0]    raw_vec, stg_vec;
    logic             s_cke, s_dqm, s_cs_n, s_ras_n, s_cas_n, s_we_n;
    logic [BA_W-1:0]  s_ba;
    logic [ROW_W-1:0] s_addr;
    logic             s_a10;
    cmd_e             dec_cmd;

    assign raw_vec = {cke, dqm, cs_n, ras_n, cas_n, we_n, ba, addr};

    sdr_in_stage #(.W(IW), .RST_VAL(IDLE_VEC)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .reg_en (reg_en),
        .d_in   (raw_vec),
        .d_out  (stg_vec)
    );

    assign {s_cke, s_dqm, s_cs_n, s_ras_n, s_cas_n, s_we_n, s_ba, s_addr} = stg_vec;
    assign s_a10 = s_addr[AP_BIT];

    sdr_cmd_decode u_dec (
        .cs_n  (s_cs_n),
        .ras_n (s_ras_n),
        .cas_n (s_cas_n),
        .we_n  (s_we_n),
        .cke   (s_cke),
        .cmd   (dec_cmd)
    );

    logic [NUM_BANKS-1:0] b_open, b_col_rdy, b_pre_rdy, open_go, close_go;
    logic [NUM_BANKS-1:0] sel, pre_tgt;
    logic [ROW_W-1:0]     b_row [NUM_BANKS];
    logic                 legal, is_col;

    typedef struct packed {
        logic [MW-1:0] mrd;
        logic          dq1;
        logic          dq2;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        sel         = '0;
        sel[s_ba]   = 1'b1;
        pre_tgt     = s_a10 ? {NUM_BANKS{1'b1}} : sel;
        is_col      = (dec_cmd == CMD_RD) || (dec_cmd == CMD_WR);
        case (dec_cmd)
            CMD_ACT:            legal = !b_open[s_ba] && (ctl_q.mrd == '0);
            CMD_RD, CMD_WR:     legal = b_col_rdy[s_ba];
            CMD_PRE:            legal = &(~pre_tgt | b_pre_rdy);
            CMD_AREF, CMD_SREF: legal = (b_open == '0) && (ctl_q.mrd == '0);
            CMD_LMR:            legal = (b_open == '0);
            default:            legal = 1'b1;
        endcase

        open_go  = (legal && dec_cmd == CMD_ACT) ? sel : '0;
        close_go = '0;
        if (legal && dec_cmd == CMD_PRE)  close_go = pre_tgt;
        if (legal && is_col && s_a10)     close_go = sel;

        ctl_d     = ctl_q;
        ctl_d.dq1 = s_dqm;
        ctl_d.dq2 = ctl_q.dq1;
        if (ctl_q.mrd != '0)               ctl_d.mrd = ctl_q.mrd - MW'(1);
        if (legal && dec_cmd == CMD_LMR)   ctl_d.mrd = MW'(T_MRD - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        sdr_bank_slot #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_go   (open_go[i]),
            .close_go  (close_go[i]),
            .row_in    (s_addr),
            .is_open   (b_open[i]),
            .row       (b_row[i]),
            .col_ready (b_col_rdy[i]),
            .pre_ready (b_pre_rdy[i])
        );
        assign bank_row[i*ROW_W +: ROW_W] = b_row[i];
    end

    assign cmd       = dec_cmd;
    assign cmd_ok    = legal;
    assign bank_open = b_open;
    assign wr_mask   = s_dqm;
    assign rd_hiz    = ctl_q.dq2;
endmodule

// File: rtl/sdr_cmd_tracker_chk.sv
module sdr_cmd_tracker_chk
    import sdr_cmd_pkg::*;
#(
    parameter int NB    = 4,
    parameter int BA_W  = 2,
    parameter int T_MRD = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      cmd,
    input logic            cmd_ok,
    input logic [NB-1:0]   bank_open,
    input logic [BA_W-1:0] stg_ba,
    input logic            stg_a10,
    input logic            stg_dqm,
    input logic            rd_hiz
);
    logic [1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    a_r1_inhibit_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_INH) |-> cmd_ok);

    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd == CMD_ACT) |=> bank_open[$past(stg_ba)]);

    a_r4_illegal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ok |=> (bank_open == $past(bank_open)));

    a_r7_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd == CMD_PRE && stg_a10) |=> (bank_open == '0));

    a_r10_hiz_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (rd_hiz == $past(stg_dqm, 2)));

    if (T_MRD >= 2) begin : g_mrd
        a_r9_mode_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_ok && cmd == CMD_LMR) |=>
            !(cmd_ok && (cmd == CMD_ACT || cmd == CMD_AREF || cmd == CMD_SREF)));
    end
endmodule

bind sdr_cmd_tracker sdr_cmd_tracker_chk #(.NB(NUM_BANKS), .BA_W(BA_W), .T_MRD(T_MRD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .cmd_ok    (cmd_ok),
    .bank_open (bank_open),
    .stg_ba    (s_ba),
    .stg_a10   (s_a10),
    .stg_dqm   (s_dqm),
    .rd_hiz    (rd_hiz)
);

// File: tb/sdr_cmd_tracker_bench.sv
`timescale 1ns/1ps
module sdr_cmd_tracker_bench;
    localparam int C_INH = 0, C_NOP = 1, C_ACT = 2, C_RD = 3, C_WR = 4,
                   C_BST = 5, C_PRE = 6, C_AREF = 7, C_SREF = 8, C_LMR = 9;

    // {cs_n, ras_n, cas_n, we_n, cke, expected code}
    localparam logic [8:0] VEC [11] = '{
        {5'b11111, 4'd0}, {5'b10001, 4'd0}, {5'b01111, 4'd1}, {5'b00111, 4'd2},
        {5'b01011, 4'd3}, {5'b01001, 4'd4}, {5'b01101, 4'd5}, {5'b00101, 4'd6},
        {5'b00011, 4'd7}, {5'b00010, 4'd8}, {5'b00001, 4'd9}
    };

    logic clk = 0, rst_n = 0, reg_en = 0;
    logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, cke = 1, dqm = 0;
    logic [1:0]  ba = 0;
    logic [11:0] addr = 0;
    logic [3:0]  cmd;
    logic        cmd_ok, wr_mask, rd_hiz;
    logic [3:0]  bank_open;
    logic [47:0] bank_row;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    sdr_cmd_tracker u_sdr_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
        .cmd(cmd), .cmd_ok(cmd_ok), .bank_open(bank_open), .bank_row(bank_row),
        .wr_mask(wr_mask), .rd_hiz(rd_hiz)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input int c, input logic [1:0] b, input logic [11:0] a);
        cs_n = (c == C_INH);
        ba   = b;
        addr = a;
        cke  = (c != C_SREF);
        case (c)
            C_ACT:          {ras_n, cas_n, we_n} = 3'b011;
            C_RD:           {ras_n, cas_n, we_n} = 3'b101;
            C_WR:           {ras_n, cas_n, we_n} = 3'b100;
            C_BST:          {ras_n, cas_n, we_n} = 3'b110;
            C_PRE:          {ras_n, cas_n, we_n} = 3'b010;
            C_AREF, C_SREF: {ras_n, cas_n, we_n} = 3'b001;
            C_LMR:          {ras_n, cas_n, we_n} = 3'b000;
            default:        {ras_n, cas_n, we_n} = 3'b111;
        endcase
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R12: reset state
        @(negedge clk);
        #1;
        chk("R12 banks idle", bank_open, 4'b0000);
        chk("R12 rd_hiz low", rd_hiz, 1'b0);
        reg_en = 1;
        issue(C_ACT, 2'd0, 12'h0);
        #1;
        chk("R12 registered cmd inhibit", cmd, C_INH);
        reg_en = 0;
        // R1/R2 truth table walk, same-clock path, held in reset so no state moves
        for (int i = 0; i < 11; i++) begin
            {cs_n, ras_n, cas_n, we_n, cke} = VEC[i][8:4];
            #0.1;
            chk($sformatf("R1/R2 decode vector %0d", i), cmd, VEC[i][3:0]);
        end
        issue(C_NOP, 2'd0, 12'h0);
        tick();
        rst_n = 1;

        // R3: activate bank 1
        issue(C_ACT, 2'd1, 12'hABC);
        #1 chk("R3 act legal", cmd_ok, 1'b1);
        tick();
        chk("R3 bank1 open", bank_open, 4'b0010);
        chk("R3 bank1 row", bank_row[23:12], 12'hABC);
        // R4: activate to open bank
        issue(C_ACT, 2'd1, 12'h123);
        #1 chk("R4 act open bank illegal", cmd_ok, 1'b0);
        tick();
        chk("R4 row kept", bank_row[23:12], 12'hABC);
        chk("R4 open kept", bank_open, 4'b0010);
        // R5: column too early, then on time
        issue(C_RD, 2'd1, 12'h000);
        #1 chk("R5 read early illegal", cmd_ok, 1'b0);
        tick();
        issue(C_RD, 2'd1, 12'h000);
        #1 chk("R5 read at T_RCD legal", cmd_ok, 1'b1);
        tick();
        chk("R8 no autoprecharge keeps open", bank_open, 4'b0010);
        // R6: precharge too early
        issue(C_PRE, 2'd1, 12'h000);
        #1 chk("R6 precharge early illegal", cmd_ok, 1'b0);
        tick();
        issue(C_PRE, 2'd1, 12'h000);
        #1 chk("R6 precharge one clock early illegal", cmd_ok, 1'b0);
        tick();
        issue(C_PRE, 2'd1, 12'h000);
        #1 chk("R6 precharge at T_RAS legal", cmd_ok, 1'b1);
        tick();
        chk("R7 single precharge closes bank1", bank_open, 4'b0000);
        // R4: read to idle bank
        issue(C_RD, 2'd2, 12'h000);
        #1 chk("R4 read idle bank illegal", cmd_ok, 1'b0);
        tick();
        chk("R4 idle bank stays idle", bank_open, 4'b0000);

        // R8: write with auto precharge
        issue(C_ACT, 2'd2, 12'h005);
        tick();
        issue(C_NOP, 2'd0, 12'h0);
        tick();
        tick();
        issue(C_WR, 2'd2, 12'h400);
        #1 chk("R8 write legal", cmd_ok, 1'b1);
        tick();
        chk("R8 autoprecharge closes bank2", bank_open, 4'b0000);

        // R7: single then all-bank precharge
        issue(C_ACT, 2'd0, 12'h111);
        tick();
        issue(C_ACT, 2'd3, 12'h333);
        tick();
        issue(C_NOP, 2'd0, 12'h0);
        for (int k = 0; k < 6; k++) tick();
        issue(C_PRE, 2'd0, 12'h000);
        #1 chk("R7 single precharge legal", cmd_ok, 1'b1);
        tick();
        chk("R7 only bank0 closed", bank_open, 4'b1000);
        issue(C_PRE, 2'd1, 12'h400);
        #1 chk("R7 all precharge legal", cmd_ok, 1'b1);
        tick();
        chk("R7 all banks closed", bank_open, 4'b0000);

        // R9: mode load spacing
        issue(C_LMR, 2'd0, 12'h032);
        #1 chk("R9 mode load legal idle", cmd_ok, 1'b1);
        tick();
        issue(C_ACT, 2'd0, 12'h0AA);
        #1 chk("R9 act after mode load illegal", cmd_ok, 1'b0);
        tick();
        chk("R9 illegal act no effect", bank_open, 4'b0000);
        issue(C_AREF, 2'd0, 12'h0);
        #1 chk("R9 refresh at T_MRD legal", cmd_ok, 1'b1);
        tick();
        issue(C_ACT, 2'd0, 12'h0AA);
        #1 chk("R3 act after gap legal", cmd_ok, 1'b1);
        tick();
        issue(C_AREF, 2'd0, 12'h0);
        #1 chk("R2 auto refresh bank open illegal", cmd_ok, 1'b0);
        chk("R2 auto refresh code", cmd, C_AREF);
        issue(C_SREF, 2'd0, 12'h0);
        #1 chk("R2 self refresh code", cmd, C_SREF);
        chk("R2 self refresh bank open illegal", cmd_ok, 1'b0);
        issue(C_LMR, 2'd0, 12'h0);
        #1 chk("R9 mode load bank open illegal", cmd_ok, 1'b0);
        issue(C_NOP, 2'd0, 12'h0);

        // R10: mask timing
        dqm = 1;
        #1 chk("R10 wr_mask same clock", wr_mask, 1'b1);
        chk("R10 rd_hiz not yet", rd_hiz, 1'b0);
        tick();
        dqm = 0;
        #1 chk("R10 wr_mask follows", wr_mask, 1'b0);
        chk("R10 rd_hiz one clock", rd_hiz, 1'b0);
        tick();
        chk("R10 rd_hiz two clocks", rd_hiz, 1'b1);
        tick();
        chk("R10 rd_hiz drops", rd_hiz, 1'b0);

        // R11: registered path
        issue(C_INH, 2'd0, 12'h0);
        tick();
        reg_en = 1;
        issue(C_BST, 2'd0, 12'h0);
        #1 chk("R11 registered delay", cmd, C_INH);
        tick();
        chk("R11 registered command", cmd, C_BST);
        issue(C_ACT, 2'd2, 12'h077);
        #1 chk("R11 previous still shown", cmd, C_BST);
        tick();
        issue(C_NOP, 2'd0, 12'h0);
        #1 chk("R11 act appears", cmd, C_ACT);
        chk("R11 act legal", cmd_ok, 1'b1);
        chk("R11 bank2 not yet open", bank_open[2], 1'b0);
        tick();
        chk("R11 bank2 open", bank_open[2], 1'b1);
        chk("R11 bank2 row", bank_row[35:24], 12'h077);
        dqm = 1;
        #1 chk("R11 wr_mask delayed", wr_mask, 1'b0);
        tick();
        chk("R11 wr_mask registered", wr_mask, 1'b1);
        dqm = 0;
        tick();

        finish_run();
    end
endmodule